// File: doc/BRIEF.md
# Lockable Access-Control Register

This block guards the mode-control registers of a power controller. It holds an access policy in one control register. The policy has three parts: a flag that lets unprivileged (user) accesses through, a flag that lets non-secure accesses through, and a whitelist with one bit per domain ID. Each write that targets the protected configuration register carries three attributes: privilege, security and domain ID. The block grants the write only when the policy admits all three. It rejects any other write, leaves the register unchanged and flags the rejection on a one-cycle error pulse.

The control register also holds three independent sticky lock bits. One freezes the privilege and security flags. One freezes the whitelist. One freezes the protected configuration contents. A lock bit can be set but never cleared by a write. Only the asynchronous power-on reset clears it. A single write may set a lock and change the field it covers; the field takes the new value in that same write. In this block the protected configuration is modelled as one scratch register. Its contents, and every policy field, are visible on output ports.

Top module: `lockable_acl_reg`

## Requirements
- R1: While `por_n` is low, and at the first clock after it rises, every policy field, every lock bit, `cfg_q` and `access_err` read 0. Asserting `por_n` clears them asynchronously, without waiting for a clock edge.
- R2: A configuration write (`wr_sel`=1) with `acc_priv`=0 is granted only when the user-enable flag (control bit 0) is 1. With `acc_priv`=1 this flag has no effect.
- R3: A configuration write with `acc_secure`=0 is granted only when the non-secure-enable flag (control bit 1) is 1. With `acc_secure`=1 this flag has no effect.
- R4: A configuration write from domain `acc_dom` is granted only when whitelist bit `acc_dom` is 1. The whitelist sits at control bits [2 +: N_DOM].
- R5: A granted configuration write loads `wr_data[CFG_W-1:0]` into `cfg_q` at the next clock, and `access_err` stays 0. A denied one leaves `cfg_q` unchanged and raises `access_err` for exactly the one cycle that follows the write.
- R6: While the policy lock (control bit 2+N_DOM) is set, writes leave the user-enable and non-secure-enable flags unchanged.
- R7: While the whitelist lock (control bit 3+N_DOM) is set, writes leave the whitelist unchanged.
- R8: While the configuration lock (control bit 4+N_DOM) is set, every configuration write is denied, whatever its attributes, with the R5 denial behaviour.
- R9: Lock bits are set-only. Writing 0 to a lock bit leaves it at 1. Only `por_n` clears it.
- R10: A control write that sets a lock also updates the fields that lock covers, because a lock takes effect only from the write after the one that sets it.
- R11: A control write (`wr_sel`=0) is accepted whatever its attributes, subject only to the locks, and never raises `access_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset; the only way to clear the locks |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 1 | Write target: 0 = control register, 1 = protected configuration register |
| wr_data | input | CFG_W | Write data |
| acc_priv | input | 1 | 1 = privileged access, 0 = user access |
| acc_secure | input | 1 | 1 = secure access, 0 = non-secure access |
| acc_dom | input | DOM_W | Domain ID of the access |
| user_en_o | output | 1 | User-enable flag |
| nonsec_en_o | output | 1 | Non-secure-enable flag |
| whitelist_o | output | N_DOM | Domain whitelist |
| lock_o | output | 3 | Locks: bit 0 policy, bit 1 whitelist, bit 2 configuration |
| cfg_q | output | CFG_W | Protected configuration register contents |
| access_err | output | 1 | One-cycle pulse after a denied configuration write |

## Verification
The bench sets a lock and changes the field it covers in the same write. A design that applied the new lock value too early would keep the old field. It then writes zeros to set locks. A design that treated the locks as plain flops would drop them, and its frozen fields would start to move. For each filter the bench tries both the admitted and the rejected attribute value. It checks that `cfg_q` holds and that `access_err` rises for only one cycle, which catches inverted polarity, a wrong whitelist index and a stuck error flag. Last, it drops `por_n` between clock edges and samples before the next edge, which shows whether the lock reset is truly asynchronous.

// File: rtl/acl_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the lockable access-control register.
// Assumes the control word places the two filter flags first, then the
// whitelist, then the three lock bits in the order given by the indices.
package acl_pkg;
    localparam int N_LOCK  = 3;
    localparam int LK_ACC  = 0;  // freezes user / non-secure flags
    localparam int LK_LIST = 1;  // freezes the domain whitelist
    localparam int LK_CFG  = 2;  // freezes the protected configuration

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_CFG  = 1'b1
    } acl_sel_e;

    // Width of the control word for a given number of domains.
    function automatic int ctrl_width(input int n_dom);
        return 2 + n_dom + N_LOCK;
    endfunction
endpackage

// File: rtl/acl_ctrl_reg.sv
`timescale 1ns/1ps
// Module: control register holding the access policy and sticky locks.
// Assumes a write strobe already qualified for this register. Locks are
// set-only and cleared only by the asynchronous power-on reset. A lock
// blocks its fields from the write after the one that sets it.
module acl_ctrl_reg
    import acl_pkg::*;
#(
    parameter int N_DOM  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wr_data,
    output logic              user_en,
    output logic              nonsec_en,
    output logic [N_DOM-1:0]  whitelist,
    output logic [N_LOCK-1:0] locks
);
    localparam int CTRL_W   = ctrl_width(N_DOM);
    localparam int B_USER   = 0;
    localparam int B_NSEC   = 1;
    localparam int B_LIST   = 2;
    localparam int B_LOCK   = 2 + N_DOM;

    // Upper data bits carry no control field.
    generate
        if (DATA_W > CTRL_W) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^wr_data[DATA_W-1:CTRL_W];
        end
    endgenerate

    // Policy flags: update unless the policy lock is already active.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            user_en   <= 1'b0;
            nonsec_en <= 1'b0;
        end else if (wr_ctrl && !locks[LK_ACC]) begin
            user_en   <= wr_data[B_USER];
            nonsec_en <= wr_data[B_NSEC];
        end
    end

    // Whitelist: update unless the whitelist lock is already active.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            whitelist <= '0;
        else if (wr_ctrl && !locks[LK_LIST])
            whitelist <= wr_data[B_LIST +: N_DOM];
    end

    // One sticky flop per lock: a write may only raise it.
    generate
        for (genvar i = 0; i < N_LOCK; i++) begin : g_lock
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n)
                    locks[i] <= 1'b0;
                else if (wr_ctrl && wr_data[B_LOCK + i])
                    locks[i] <= 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/acl_policy.sv
`timescale 1ns/1ps
// Module: combinational grant decision for protected-register writes.
// Assumes the policy fields are stable registers. Domain IDs beyond the
// whitelist width are refused when the ID field can express them.
module acl_policy #(
    parameter int N_DOM = 2,
    parameter int DOM_W = 1
) (
    input  logic             acc_priv,
    input  logic             acc_secure,
    input  logic [DOM_W-1:0] acc_dom,
    input  logic             user_en,
    input  logic             nonsec_en,
    input  logic [N_DOM-1:0] whitelist,
    input  logic             cfg_locked,
    output logic             grant
);
    logic dom_ok;

    // Whitelist lookup, with a range guard only if IDs can exceed N_DOM.
    generate
        if (N_DOM == (1 << DOM_W)) begin : g_full
            assign dom_ok = whitelist[acc_dom];
        end else begin : g_part
            localparam int IDX_W = DOM_W + 1;
            logic [IDX_W-1:0] dom_ext;
            assign dom_ext = {1'b0, acc_dom};
            always_comb begin
                dom_ok = 1'b0;
                for (int d = 0; d < N_DOM; d++)
                    if (dom_ext == IDX_W'(d)) dom_ok = whitelist[d];
            end
        end
    endgenerate

    // All three filters and the configuration lock must agree.
    always_comb begin
        grant = (acc_priv | user_en) & (acc_secure | nonsec_en) &
                dom_ok & ~cfg_locked;
    end
endmodule

// File: rtl/acl_cfg_store.sv
`timescale 1ns/1ps
// Module: protected configuration register plus the denial pulse.
// Assumes the grant is valid in the cycle of the write strobe.
module acl_cfg_store #(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_cfg,
    input  logic             grant,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q,
    output logic             access_err
);
    // Load the contents only on a granted write.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            cfg_q <= '0;
        else if (wr_cfg && grant)
            cfg_q <= wr_data;
    end

    // Error pulse for one cycle after each refused write.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            access_err <= 1'b0;
        else
            access_err <= wr_cfg && !grant;
    end
endmodule

// File: rtl/lockable_acl_reg.sv
`timescale 1ns/1ps
// Module: top of the lockable access-control register.
// Routes each write to the control register or the protected
// configuration register, and gates the latter with the policy.
// Assumes at most one write per cycle and a data width that covers the
// control word.
module lockable_acl_reg
    import acl_pkg::*;
#(
    parameter int N_DOM = 2,
    parameter int CFG_W = 16,
    parameter int DOM_W = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic              acc_priv,
    input  logic              acc_secure,
    input  logic [DOM_W-1:0]  acc_dom,
    output logic              user_en_o,
    output logic              nonsec_en_o,
    output logic [N_DOM-1:0]  whitelist_o,
    output logic [N_LOCK-1:0] lock_o,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              access_err
);
    localparam int CTRL_W = ctrl_width(N_DOM);

    logic wr_ctrl;
    logic wr_cfg;
    logic grant;

    // Decode the write target.
    always_comb begin
        wr_ctrl = wr_en && (acl_sel_e'(wr_sel) == SEL_CTRL);
        wr_cfg  = wr_en && (acl_sel_e'(wr_sel) == SEL_CFG);
    end

    generate
        if (CFG_W < CTRL_W) begin : g_bad_width
            initial $error("CFG_W must hold the control word");
        end
    endgenerate

    acl_ctrl_reg #(.N_DOM(N_DOM), .DATA_W(CFG_W)) u_ctrl (
        .clk       (clk),
        .por_n     (por_n),
        .wr_ctrl   (wr_ctrl),
        .wr_data   (wr_data),
        .user_en   (user_en_o),
        .nonsec_en (nonsec_en_o),
        .whitelist (whitelist_o),
        .locks     (lock_o)
    );

    acl_policy #(.N_DOM(N_DOM), .DOM_W(DOM_W)) u_policy (
        .acc_priv   (acc_priv),
        .acc_secure (acc_secure),
        .acc_dom    (acc_dom),
        .user_en    (user_en_o),
        .nonsec_en  (nonsec_en_o),
        .whitelist  (whitelist_o),
        .cfg_locked (lock_o[LK_CFG]),
        .grant      (grant)
    );

    acl_cfg_store #(.CFG_W(CFG_W)) u_store (
        .clk        (clk),
        .por_n      (por_n),
        .wr_cfg     (wr_cfg),
        .grant      (grant),
        .wr_data    (wr_data),
        .cfg_q      (cfg_q),
        .access_err (access_err)
    );
endmodule

// File: rtl/lockable_acl_reg_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the lockable access-control register,
// observed at its ports only.
module lockable_acl_reg_chk #(
    parameter int N_DOM = 2,
    parameter int CFG_W = 16
) (
    input logic             clk,
    input logic             por_n,
    input logic             wr_en,
    input logic             wr_sel,
    input logic             acc_priv,
    input logic             user_en_o,
    input logic             nonsec_en_o,
    input logic [N_DOM-1:0] whitelist_o,
    input logic [2:0]       lock_o,
    input logic [CFG_W-1:0] cfg_q,
    input logic             access_err
);
    // R5: an error pulse is always caused by a configuration write.
    assert_err_cause_R5: assert property (@(posedge clk) disable iff (!por_n)
        access_err |-> $past(wr_en && wr_sel));

    // R2: an unprivileged write without user enable is refused.
    assert_user_deny_R2: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && wr_sel && !acc_priv && !user_en_o) |=> access_err);

    // R8: a configuration lock refuses writes and freezes the contents.
    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && wr_sel && lock_o[2]) |=> (access_err && $stable(cfg_q)));

    // R6: the policy lock freezes both filter flags.
    assert_policy_frozen_R6: assert property (@(posedge clk) disable iff (!por_n)
        lock_o[0] |=> $stable({user_en_o, nonsec_en_o}));

    // R7: the whitelist lock freezes the whitelist.
    assert_list_frozen_R7: assert property (@(posedge clk) disable iff (!por_n)
        lock_o[1] |=> $stable(whitelist_o));

    // R9: no lock bit ever falls while out of reset.
    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> (($past(lock_o) & ~lock_o) == 3'b000));

    // R11: control writes never raise the error pulse.
    assert_ctrl_noerr_R11: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !wr_sel) |=> !access_err);
endmodule

bind lockable_acl_reg lockable_acl_reg_chk #(.N_DOM(N_DOM), .CFG_W(CFG_W)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .acc_priv    (acc_priv),
    .user_en_o   (user_en_o),
    .nonsec_en_o (nonsec_en_o),
    .whitelist_o (whitelist_o),
    .lock_o      (lock_o),
    .cfg_q       (cfg_q),
    .access_err  (access_err)
);

// File: tb/lockable_acl_reg_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module lockable_acl_reg_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        acc_priv = 1'b0;
    logic        acc_secure = 1'b0;
    logic [0:0]  acc_dom = '0;
    logic        user_en_o, nonsec_en_o;
    logic [1:0]  whitelist_o;
    logic [2:0]  lock_o;
    logic [15:0] cfg_q;
    logic        access_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    lockable_acl_reg uut (
        .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .acc_priv(acc_priv), .acc_secure(acc_secure),
        .acc_dom(acc_dom), .user_en_o(user_en_o), .nonsec_en_o(nonsec_en_o),
        .whitelist_o(whitelist_o), .lock_o(lock_o), .cfg_q(cfg_q),
        .access_err(access_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Control word: bit0 user, bit1 non-secure, [3:2] whitelist, 4..6 locks.
    function automatic logic [15:0] mk(input logic u, input logic ns,
                                       input logic [1:0] wl, input logic la,
                                       input logic ll, input logic lc);
        return {9'b0, lc, ll, la, wl, ns, u};
    endfunction

    // One write cycle; returns at the negedge where results are visible.
    task automatic wr(input logic sel, input logic [15:0] d, input logic p,
                      input logic s, input logic dm);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        acc_priv = p; acc_secure = s; acc_dom = dm;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "cfg in reset", 32'(cfg_q), 0);
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        chk("R1", "user", 32'(user_en_o), 0);
        chk("R1", "nonsec", 32'(nonsec_en_o), 0);
        chk("R1", "list", 32'(whitelist_o), 0);
        chk("R1", "locks", 32'(lock_o), 0);
        chk("R1", "cfg", 32'(cfg_q), 0);
        chk("R1", "err", 32'(access_err), 0);
    endtask

    task automatic t_user;
        wr(1'b0, mk(0, 1, 2'b11, 0, 0, 0), 1, 1, 0);
        wr(1'b1, 16'h0011, 0, 1, 0);
        chk("R2", "user write denied cfg", 32'(cfg_q), 0);
        chk("R2", "user write denied err", 32'(access_err), 1);
        wr(1'b1, 16'h0022, 1, 1, 0);
        chk("R2", "priv write cfg", 32'(cfg_q), 32'h22);
        chk("R5", "granted err", 32'(access_err), 0);
        wr(1'b0, mk(1, 1, 2'b11, 0, 0, 0), 1, 1, 0);
        wr(1'b1, 16'h0033, 0, 1, 0);
        chk("R2", "user allowed cfg", 32'(cfg_q), 32'h33);
    endtask

    task automatic t_nonsec;
        wr(1'b0, mk(1, 0, 2'b11, 0, 0, 0), 1, 1, 0);
        wr(1'b1, 16'h0044, 1, 0, 0);
        chk("R3", "nonsec denied cfg", 32'(cfg_q), 32'h33);
        chk("R3", "nonsec denied err", 32'(access_err), 1);
        wr(1'b1, 16'h0055, 1, 1, 0);
        chk("R3", "secure cfg", 32'(cfg_q), 32'h55);
        wr(1'b0, mk(1, 1, 2'b11, 0, 0, 0), 1, 1, 0);
        wr(1'b1, 16'h0066, 1, 0, 0);
        chk("R3", "nonsec allowed cfg", 32'(cfg_q), 32'h66);
    endtask

    task automatic t_list;
        wr(1'b0, mk(1, 1, 2'b01, 0, 0, 0), 1, 1, 0);
        wr(1'b1, 16'h0077, 1, 1, 1);
        chk("R4", "dom1 denied cfg", 32'(cfg_q), 32'h66);
        chk("R4", "dom1 denied err", 32'(access_err), 1);
        wr(1'b1, 16'h0088, 1, 1, 0);
        chk("R4", "dom0 cfg", 32'(cfg_q), 32'h88);
        wr(1'b0, mk(1, 1, 2'b10, 0, 0, 0), 1, 1, 0);
        wr(1'b1, 16'h0099, 1, 1, 0);
        chk("R4", "dom0 denied cfg", 32'(cfg_q), 32'h88);
        wr(1'b1, 16'h00AA, 1, 1, 1);
        chk("R4", "dom1 cfg", 32'(cfg_q), 32'hAA);
    endtask

    task automatic t_pulse;
        wr(1'b0, mk(0, 0, 2'b11, 0, 0, 0), 1, 1, 0);
        wr(1'b1, 16'h0BAD, 0, 0, 0);
        chk("R5", "pulse high", 32'(access_err), 1);
        chk("R5", "cfg held", 32'(cfg_q), 32'hAA);
        @(negedge clk);
        chk("R5", "pulse one cycle", 32'(access_err), 0);
    endtask

    task automatic t_ctrl_any;
        wr(1'b0, mk(1, 0, 2'b01, 0, 0, 0), 0, 0, 1);
        chk("R11", "unpriv ctrl user", 32'(user_en_o), 1);
        chk("R11", "unpriv ctrl list", 32'(whitelist_o), 32'h1);
        chk("R11", "ctrl no err", 32'(access_err), 0);
    endtask

    task automatic t_locks;
        wr(1'b0, mk(1, 1, 2'b11, 1, 0, 0), 0, 0, 0);
        chk("R10", "user with lock", 32'(user_en_o), 1);
        chk("R10", "nonsec with lock", 32'(nonsec_en_o), 1);
        chk("R10", "lock captured", 32'(lock_o), 32'h1);
        wr(1'b0, mk(0, 0, 2'b01, 0, 0, 0), 1, 1, 0);
        chk("R6", "user frozen", 32'(user_en_o), 1);
        chk("R6", "nonsec frozen", 32'(nonsec_en_o), 1);
        chk("R9", "lock kept on zero write", 32'(lock_o), 32'h1);
        chk("R7", "list free before lock", 32'(whitelist_o), 32'h1);
        wr(1'b0, mk(0, 0, 2'b10, 0, 1, 0), 1, 1, 0);
        chk("R10", "list with lock", 32'(whitelist_o), 32'h2);
        chk("R9", "locks accumulate", 32'(lock_o), 32'h3);
        wr(1'b0, mk(0, 0, 2'b11, 0, 0, 0), 1, 1, 0);
        chk("R7", "list frozen", 32'(whitelist_o), 32'h2);
        wr(1'b1, 16'hBEEF, 0, 0, 1);
        chk("R4", "locked policy grants dom1", 32'(cfg_q), 32'hBEEF);
        wr(1'b0, mk(0, 0, 2'b00, 0, 0, 1), 1, 1, 0);
        chk("R9", "all locks", 32'(lock_o), 32'h7);
        wr(1'b1, 16'h1234, 1, 1, 1);
        chk("R8", "cfg locked", 32'(cfg_q), 32'hBEEF);
        chk("R8", "cfg locked err", 32'(access_err), 1);
        @(negedge clk);
        #5 por_n = 1'b0;
        #2;
        chk("R9", "async clear locks", 32'(lock_o), 0);
        chk("R1", "async clear cfg", 32'(cfg_q), 0);
        chk("R1", "async clear user", 32'(user_en_o), 0);
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        chk("R9", "locks stay clear", 32'(lock_o), 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset;
        t_user;
        t_nonsec;
        t_list;
        t_pulse;
        t_ctrl_any;
        t_locks;
        finish_run;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end
endmodule